// File: doc/BRIEF.md
# State-Gated Event Sequencer

This block holds a small state register that decides which of a set of event triggers may take effect, and turns each effective event into action strobes for the surrounding timer logic. Those strobes are: drive outputs high or low, limit, halt or restart the counter, and raise an interrupt or a DMA request. Every event carries a 32-entry enable mask indexed by the current state value. An event counts only when its trigger is high and the mask bit selected by its state half is set. An effective event may also rewrite the state, either by loading a constant or by adding a constant modulo 32. This lets software describe a sequence that moves from one step to the next as events occur.

The state can run as one unified 5-bit variable or as two independent 5-bit halves. In split mode each event belongs to one half: it is gated by that half and it updates only that half. A register port can read both halves in one 32-bit word and write either half alone or both halves together. Counters, comparators and pins lie outside this block, and triggers arrive already decoded.

Top module: `evt_state_seq`

## Requirements
- R1: During and after reset both state halves read zero, and `evt_fired` and every action strobe are low.
- R2: Event i fires when `evt_trig[i]` is high and bit s of its mask is set, where s is the current value of the half the event is gated by. `evt_fired[i]` reflects this one clock after the trigger is sampled.
- R3: Action strobes are registered with `evt_fired`. `out_set`/`out_clr` are the OR of the set/clear masks of all fired events. Each `cfg_act` field is 5 bits: bit 0 limit, bit 1 stop, bit 2 start, bit 3 interrupt, bit 4 DMA. Each bit is ORed over the fired events onto the matching strobe.
- R4: A fired event with its change bit set and mode bit 0 loads its 5-bit state value into its half.
- R5: A fired event with its change bit set and mode bit 1 adds its 5-bit value to its half, wrapping modulo 32.
- R6: When several fired events update the same half in one cycle, the highest-numbered one decides the new value.
- R7: A register write to a half in the same cycle as an event update of that half wins over the event.
- R8: With `unify` high, every event is gated by the low half and updates only the low half. The high half changes only through register writes.
- R9: With `unify` low, an event whose half bit is 1 is gated by the high half and updates only the high half; half bit 0 selects the low half.
- R10: `rd_data` carries the low half at bits 4:0 and the high half at bits 20:16, all other bits zero. `wr_lo` writes bits 4:0 of `wr_data` to the low half, and `wr_hi` writes bits 20:16 to the high half. Either may be used alone or both together.
- R11: A half changes only through a write or a fired event with its change bit set for that half; otherwise it holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| unify | input | 1 | 1: single state variable (low half); 0: two halves |
| evt_trig | input | NE | Per-event trigger |
| cfg_mask | input | NE*32 | Per-event state-enable mask, event i at bits i*32 +: 32 |
| cfg_sval | input | NE*5 | Per-event state load/add value |
| cfg_add | input | NE | Per-event mode: 0 load, 1 add |
| cfg_chg | input | NE | Per-event state-change enable |
| cfg_half | input | NE | Per-event half select in split mode: 0 low, 1 high |
| cfg_oset | input | NE*NO | Per-event output-set mask |
| cfg_oclr | input | NE*NO | Per-event output-clear mask |
| cfg_act | input | NE*5 | Per-event counter/request action bits |
| wr_lo | input | 1 | Write low half from wr_data[4:0] |
| wr_hi | input | 1 | Write high half from wr_data[20:16] |
| wr_data | input | 32 | Write data word |
| rd_data | output | 32 | Read word of both halves |
| evt_fired | output | NE | Registered fired-event flags |
| out_set | output | NO | Output set strobes |
| out_clr | output | NO | Output clear strobes |
| ctr_limit | output | 1 | Counter limit strobe |
| ctr_stop | output | 1 | Counter stop strobe |
| ctr_start | output | 1 | Counter start strobe |
| irq_req | output | 1 | Interrupt request strobe |
| dma_req | output | 1 | DMA request strobe |

## Verification
A corrupted state half shows on `rd_data` at the very next clock, because the state is visible there directly. It also shows as a wrong `evt_fired` pattern on the first trigger whose mask separates the right state from the wrong one. A wrong winner among simultaneous updaters, or a missing wrap in add mode, shows as a wrong value one clock after the event. A wrong half selection shows on the unaffected half as a change that should not occur. Comparing every output against a reference model on every clock, under directed sequences and random traffic in both modes, therefore catches such a fault within one or two cycles of its cause.

// File: rtl/evt_seq_pkg.sv
package evt_seq_pkg;
    localparam int ACT_W     = 5;
    localparam int ACT_LIMIT = 0;
    localparam int ACT_STOP  = 1;
    localparam int ACT_START = 2;
    localparam int ACT_IRQ   = 3;
    localparam int ACT_DMA   = 4;

    typedef enum logic {
        HALF_LO = 1'b0,
        HALF_HI = 1'b1
    } half_e;

    typedef enum logic {
        UPD_LOAD = 1'b0,
        UPD_ADD  = 1'b1
    } upd_mode_e;
endpackage

// File: rtl/evt_gate.sv
module evt_gate #(
    parameter int NE  = 8,
    parameter int STW = 5,
    localparam int NST = 1 << STW
) (
    input  logic              unify,
    input  logic [STW-1:0]    st_lo,
    input  logic [STW-1:0]    st_hi,
    input  logic [NE-1:0]     trig,
    input  logic [NE*NST-1:0] mask,
    input  logic [NE-1:0]     half,
    output logic [NE-1:0]     fire,
    output logic [NE-1:0]     eff_half
);
    import evt_seq_pkg::*;

    for (genvar i = 0; i < NE; i++) begin : g_evt
        logic [NST-1:0] m;
        logic [STW-1:0] cur;
        assign m           = mask[i*NST +: NST];
        assign eff_half[i] = unify ? HALF_LO : half[i];
        assign cur         = (eff_half[i] == HALF_HI) ? st_hi : st_lo;
        assign fire[i]     = trig[i] & m[cur];
    end
endmodule

// File: rtl/half_upd.sv
module half_upd #(
    parameter int NE  = 8,
    parameter int STW = 5,
    parameter bit SEL = 1'b0
) (
    input  logic [STW-1:0]    cur,
    input  logic [NE-1:0]     fire,
    input  logic [NE-1:0]     eff_half,
    input  logic [NE-1:0]     chg,
    input  logic [NE-1:0]     add,
    input  logic [NE*STW-1:0] sval,
    input  logic              wr,
    input  logic [STW-1:0]    wr_val,
    output logic [STW-1:0]    nxt
);
    import evt_seq_pkg::*;

    always_comb begin
        nxt = cur;
        // ascending scan: the last (highest-numbered) hit decides
        for (int i = 0; i < NE; i++) begin
            if (fire[i] && chg[i] && (eff_half[i] == SEL)) begin
                if (add[i] == UPD_ADD)
                    nxt = cur + sval[i*STW +: STW];
                else
                    nxt = sval[i*STW +: STW];
            end
        end
        if (wr)
            nxt = wr_val;
    end
endmodule

// File: rtl/act_merge.sv
module act_merge #(
    parameter int NE = 8,
    parameter int NO = 4,
    parameter int AW = evt_seq_pkg::ACT_W
) (
    input  logic [NE-1:0]    fire,
    input  logic [NE*NO-1:0] oset,
    input  logic [NE*NO-1:0] oclr,
    input  logic [NE*AW-1:0] act,
    output logic [NO-1:0]    set_or,
    output logic [NO-1:0]    clr_or,
    output logic [AW-1:0]    act_or
);
    always_comb begin
        set_or = '0;
        clr_or = '0;
        act_or = '0;
        for (int i = 0; i < NE; i++) begin
            if (fire[i]) begin
                set_or = set_or | oset[i*NO +: NO];
                clr_or = clr_or | oclr[i*NO +: NO];
                act_or = act_or | act[i*AW +: AW];
            end
        end
    end
endmodule

// File: rtl/evt_state_seq.sv
module evt_state_seq
    import evt_seq_pkg::*;
#(
    parameter int NE  = 8,
    parameter int NO  = 4,
    parameter int STW = 5,
    localparam int NST   = 1 << STW,
    localparam int HI_LSB = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              unify,
    input  logic [NE-1:0]     evt_trig,
    input  logic [NE*NST-1:0] cfg_mask,
    input  logic [NE*STW-1:0] cfg_sval,
    input  logic [NE-1:0]     cfg_add,
    input  logic [NE-1:0]     cfg_chg,
    input  logic [NE-1:0]     cfg_half,
    input  logic [NE*NO-1:0]  cfg_oset,
    input  logic [NE*NO-1:0]  cfg_oclr,
    input  logic [NE*ACT_W-1:0] cfg_act,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [31:0]       wr_data,
    output logic [31:0]       rd_data,
    output logic [NE-1:0]     evt_fired,
    output logic [NO-1:0]     out_set,
    output logic [NO-1:0]     out_clr,
    output logic              ctr_limit,
    output logic              ctr_stop,
    output logic              ctr_start,
    output logic              irq_req,
    output logic              dma_req
);
    typedef struct packed {
        logic [STW-1:0]   lo;
        logic [STW-1:0]   hi;
        logic [NE-1:0]    fired;
        logic [NO-1:0]    oset;
        logic [NO-1:0]    oclr;
        logic [ACT_W-1:0] act;
    } seq_t;

    seq_t s_d, s_q;

    logic [NE-1:0]    fire, eff_half;
    logic [STW-1:0]   lo_nxt, hi_nxt;
    logic [NO-1:0]    set_or, clr_or;
    logic [ACT_W-1:0] act_or;
    logic             unused_wr;

    assign unused_wr = ^{wr_data[31:HI_LSB+STW], wr_data[HI_LSB-1:STW]};

    evt_gate #(.NE(NE), .STW(STW)) u_gate (
        .unify    (unify),
        .st_lo    (s_q.lo),
        .st_hi    (s_q.hi),
        .trig     (evt_trig),
        .mask     (cfg_mask),
        .half     (cfg_half),
        .fire     (fire),
        .eff_half (eff_half)
    );

    for (genvar h = 0; h < 2; h++) begin : g_half
        logic [STW-1:0] cur, nxt, wval;
        logic           wr;
        if (h == 0) begin : g_lo
            assign cur    = s_q.lo;
            assign wr     = wr_lo;
            assign wval   = wr_data[STW-1:0];
            assign lo_nxt = nxt;
        end else begin : g_hi
            assign cur    = s_q.hi;
            assign wr     = wr_hi;
            assign wval   = wr_data[HI_LSB +: STW];
            assign hi_nxt = nxt;
        end
        half_upd #(.NE(NE), .STW(STW), .SEL(h[0])) u_upd (
            .cur      (cur),
            .fire     (fire),
            .eff_half (eff_half),
            .chg      (cfg_chg),
            .add      (cfg_add),
            .sval     (cfg_sval),
            .wr       (wr),
            .wr_val   (wval),
            .nxt      (nxt)
        );
    end

    act_merge #(.NE(NE), .NO(NO), .AW(ACT_W)) u_act (
        .fire   (fire),
        .oset   (cfg_oset),
        .oclr   (cfg_oclr),
        .act    (cfg_act),
        .set_or (set_or),
        .clr_or (clr_or),
        .act_or (act_or)
    );

    always_comb begin
        s_d       = s_q;
        s_d.lo    = lo_nxt;
        s_d.hi    = hi_nxt;
        s_d.fired = fire;
        s_d.oset  = set_or;
        s_d.oclr  = clr_or;
        s_d.act   = act_or;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_comb begin
        rd_data                   = '0;
        rd_data[STW-1:0]          = s_q.lo;
        rd_data[HI_LSB +: STW]    = s_q.hi;
    end

    assign evt_fired = s_q.fired;
    assign out_set   = s_q.oset;
    assign out_clr   = s_q.oclr;
    assign ctr_limit = s_q.act[ACT_LIMIT];
    assign ctr_stop  = s_q.act[ACT_STOP];
    assign ctr_start = s_q.act[ACT_START];
    assign irq_req   = s_q.act[ACT_IRQ];
    assign dma_req   = s_q.act[ACT_DMA];
endmodule

// File: rtl/evt_state_seq_chk.sv
module evt_state_seq_chk #(
    parameter int NE  = 8,
    parameter int NO  = 4,
    parameter int STW = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          unify,
    input logic [NE-1:0] evt_trig,
    input logic          wr_lo,
    input logic          wr_hi,
    input logic [31:0]   wr_data,
    input logic [31:0]   rd_data,
    input logic [NE-1:0] evt_fired,
    input logic [NO-1:0] out_set
);
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (rd_data == 32'd0 && evt_fired == '0));

    p_fire_needs_trig_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_fired & ~$past(evt_trig)) == '0);

    p_set_from_fire_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (|out_set) |-> (|evt_fired));

    p_write_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_lo |=> (rd_data[STW-1:0] == $past(wr_data[STW-1:0])));

    p_unified_hi_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (unify && !wr_hi) |=> $stable(rd_data[16 +: STW]));

    p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_trig == '0 && !wr_lo && !wr_hi) |=> $stable(rd_data));
endmodule

bind evt_state_seq evt_state_seq_chk #(.NE(NE), .NO(NO), .STW(STW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .unify     (unify),
    .evt_trig  (evt_trig),
    .wr_lo     (wr_lo),
    .wr_hi     (wr_hi),
    .wr_data   (wr_data),
    .rd_data   (rd_data),
    .evt_fired (evt_fired),
    .out_set   (out_set)
);

// File: tb/sim_evt_state_seq.sv
module sim_evt_state_seq;
    localparam int CLK_PERIOD = 10;
    localparam int NE = 8, NO = 4, STW = 5, NST = 32, AW = 5;

    logic clk = 1'b0, rst_n = 1'b0, unify = 1'b0;
    logic [NE-1:0]     evt_trig = '0;
    logic [NE*NST-1:0] cfg_mask = '0;
    logic [NE*STW-1:0] cfg_sval = '0;
    logic [NE-1:0]     cfg_add = '0, cfg_chg = '0, cfg_half = '0;
    logic [NE*NO-1:0]  cfg_oset = '0, cfg_oclr = '0;
    logic [NE*AW-1:0]  cfg_act = '0;
    logic              wr_lo = 1'b0, wr_hi = 1'b0;
    logic [31:0]       wr_data = '0;
    logic [31:0]       rd_data;
    logic [NE-1:0]     evt_fired;
    logic [NO-1:0]     out_set, out_clr;
    logic              ctr_limit, ctr_stop, ctr_start, irq_req, dma_req;

    int n_run = 0, n_fail = 0;
    int m_lo = 0, m_hi = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    evt_state_seq #(.NE(NE), .NO(NO), .STW(STW)) u0 (.*);

    function automatic logic [AW+2*NO+NE+31:0] pack_out();
        return {rd_data, evt_fired, out_set, out_clr,
                dma_req, irq_req, ctr_start, ctr_stop, ctr_limit};
    endfunction

    task automatic compare(input string tag, input logic [AW+2*NO+NE+31:0] exp);
        logic [AW+2*NO+NE+31:0] act;
        act = pack_out();
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // drive at negedge, predict, check at next negedge
    task automatic tick(input string tag, input logic [NE-1:0] trig,
                        input logic wl, input logic wh, input logic [31:0] wd);
        int nlo, nhi, h, cur;
        logic [NE-1:0] f;
        logic [NO-1:0] es, ec;
        logic [AW-1:0] ea;
        logic [31:0]   rd;
        evt_trig = trig; wr_lo = wl; wr_hi = wh; wr_data = wd;
        nlo = m_lo; nhi = m_hi; f = '0; es = '0; ec = '0; ea = '0;
        for (int i = 0; i < NE; i++) begin
            h   = unify ? 0 : int'(cfg_half[i]);
            cur = (h == 1) ? m_hi : m_lo;
            f[i] = trig[i] && cfg_mask[i*NST + cur];
            if (f[i]) begin
                es |= cfg_oset[i*NO +: NO];
                ec |= cfg_oclr[i*NO +: NO];
                ea |= cfg_act[i*AW +: AW];
                if (cfg_chg[i]) begin
                    int v;
                    v = cfg_add[i] ? (cur + int'(cfg_sval[i*STW +: STW])) % 32
                                   : int'(cfg_sval[i*STW +: STW]);
                    if (h == 1) nhi = v; else nlo = v;
                end
            end
        end
        if (wl) nlo = int'(wd[4:0]);
        if (wh) nhi = int'(wd[20:16]);
        m_lo = nlo; m_hi = nhi;
        rd = 32'(m_lo) | (32'(m_hi) << 16);
        @(posedge clk);
        @(negedge clk);
        compare(tag, {rd, f, es, ec, ea});
    endtask

    task automatic cfg_evt(input int i, input logic [31:0] msk, input int sv,
                           input logic add, input logic chg, input logic hf,
                           input logic [NO-1:0] os, input logic [NO-1:0] oc,
                           input logic [AW-1:0] ac);
        cfg_mask[i*NST +: NST] = msk;
        cfg_sval[i*STW +: STW] = STW'(sv);
        cfg_add[i] = add; cfg_chg[i] = chg; cfg_half[i] = hf;
        cfg_oset[i*NO +: NO] = os; cfg_oclr[i*NO +: NO] = oc;
        cfg_act[i*AW +: AW] = ac;
    endtask

    initial begin
        #(CLK_PERIOD*200000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        // act bits: 0 limit, 1 stop, 2 start, 3 irq, 4 dma
        cfg_evt(0, 32'h1,        3,  1'b0, 1'b1, 1'b0, 4'b0001, 4'b0000, 5'b01000);
        cfg_evt(1, 32'h8,        2,  1'b1, 1'b1, 1'b0, 4'b0000, 4'b0100, 5'b00011);
        cfg_evt(2, 32'h1,        7,  1'b0, 1'b1, 1'b1, 4'b0000, 4'b0010, 5'b10000);
        cfg_evt(3, 32'h80,       31, 1'b1, 1'b1, 1'b1, 4'b1000, 4'b0000, 5'b00000);
        cfg_evt(4, 32'hFFFFFFFF, 9,  1'b0, 1'b0, 1'b0, 4'b0000, 4'b0000, 5'b00100);
        cfg_evt(5, 32'h20,       9,  1'b0, 1'b1, 1'b0, 4'b0010, 4'b0000, 5'b00000);
        cfg_evt(6, 32'h20,       12, 1'b0, 1'b1, 1'b0, 4'b0000, 4'b0001, 5'b00000);
        cfg_evt(7, 32'h1000,     0,  1'b0, 1'b1, 1'b0, 4'b0100, 4'b0000, 5'b01000);
        repeat (3) @(negedge clk);
        compare("R1", '0);
        rst_n = 1'b1;
        tick("R11", '0, 1'b0, 1'b0, '0);
        tick("R2",  8'h02, 1'b0, 1'b0, '0);       // ev1 not enabled in state 0
        tick("R4",  8'h01, 1'b0, 1'b0, '0);       // load 3, set out0, irq
        tick("R5",  8'h02, 1'b0, 1'b0, '0);       // 3+2 = 5, limit+stop
        tick("R9",  8'h14, 1'b0, 1'b0, '0);       // high half 0->7, ev4 start only
        tick("R5",  8'h08, 1'b0, 1'b0, '0);       // 7+31 wraps to 6
        tick("R6",  8'h60, 1'b0, 1'b0, '0);       // 9 vs 12, ev6 wins
        tick("R3",  8'h90, 1'b0, 1'b0, '0);       // merged strobes ev4+ev7
        tick("R10", '0, 1'b1, 1'b1, 32'hFFFFFFFF);
        tick("R10", '0, 1'b0, 1'b1, 32'h0004_0000);
        tick("R7",  8'h20, 1'b1, 1'b0, 32'h0000_0005);
        tick("R7",  8'h60, 1'b1, 1'b0, 32'h0000_0014);
        unify = 1'b1;
        tick("R8",  '0, 1'b1, 1'b1, 32'h0003_0000);
        tick("R8",  8'h04, 1'b0, 1'b0, '0);       // gated by low 0, writes low 7
        tick("R8",  8'h08, 1'b0, 1'b0, '0);       // low 7 + 31 = 6, high stays 3
        for (int k = 0; k < 400; k++) begin
            logic [NE-1:0] t;
            logic wl, wh;
            if (k % 50 == 0) unify = ~unify;
            t  = NE'($urandom);
            wl = ($urandom % 8) == 0;
            wh = ($urandom % 8) == 0;
            tick(unify ? "R8" : "R2", t, wl, wh, $urandom);
        end
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule